// File: doc/BRIEF.md
# ADC Conversion Window Monitor

This block sits behind a successive-approximation converter and inspects every finished conversion without any processor action. When the converter pulses its done strobe, the block captures the raw 12-bit code and the justification setting. One cycle later it publishes the code as a 16-bit result word. In left-justified form the code occupies the top twelve bits. In right-justified form the code occupies the low twelve bits and the four upper bits are fill.

In the same cycle, the published word is compared with two 16-bit limits that software programs: a lower bound and an upper bound. If the word lies strictly above the lower bound and strictly below the upper bound, a sticky window flag is raised. A word outside the window, or exactly equal to either bound, leaves the flag as it was. Software clears the flag with a one-cycle clear pulse. Because the comparison uses the justified word, the same raw code can fall inside or outside a window depending on the justify setting.

Top module: `adc_window_monitor`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `data_word` is 0x0000 and `win_flag` is 0.
- R2: With `left_just` = 1 at the strobe, `data_word[15:4]` equals the raw code and `data_word[3:0]` is 0.
- R3: With `left_just` = 0 at the strobe, `data_word[11:0]` equals the raw code. With the default parameter `SIGN_FILL` = 0, `data_word[15:12]` is 0. With `SIGN_FILL` = 1, each of those four bits copies raw bit 11.
- R4: `win_flag` becomes 1 when the justified word W satisfies `gt_limit` < W < `lt_limit`, both comparisons unsigned over 16 bits. For example, with limits 0x1000 and 0x2000, the words 0x1010 and 0x1FF0 set the flag.
- R5: A word equal to `gt_limit` or equal to `lt_limit` does not set the flag.
- R6: A word outside the window leaves `win_flag` unchanged, whether it was 0 or 1. With limits 0x1000 and 0x2000, this holds for 0x0FF0 and 0x2010.
- R7: A high `flag_clr` at a rising edge clears `win_flag` at that edge. If a window hit is registered at the same edge, the hit wins and the flag stays 1.
- R8: `raw_code` and `left_just` are sampled at the rising edge where `conv_done` is high. `data_word` and `win_flag` take the new result at the following rising edge, and the limits are sampled at that second edge.
- R9: Without a strobe, changes on `raw_code`, `left_just` or the limits change neither `data_word` nor `win_flag`.
- R10: Strobes on consecutive cycles are each processed, one result per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle pulse when a conversion has finished |
| raw_code | input | 12 | Raw conversion result |
| left_just | input | 1 | 1 selects left-justified formatting, 0 selects right-justified |
| gt_limit | input | 16 | Lower window bound; the word must be strictly greater |
| lt_limit | input | 16 | Upper window bound; the word must be strictly less |
| flag_clr | input | 1 | Clear pulse for the sticky window flag |
| data_word | output | 16 | Justified result word |
| win_flag | output | 1 | Sticky flag for a result inside the window |

## Verification
On every cycle, the checker confirms several properties. A strobe is always followed by a captured stage. A compare hit always sets the flag on the next cycle. The flag holds when there is neither a hit nor a clear, and a clear without a hit drops it. The word holds when no stage is pending. The fill and zero bits of the word follow the justify setting sampled two cycles earlier. The checker cannot decide whether a given word really lies inside the window, including at the exact bounds. It also cannot confirm that the same raw code is judged differently under the two justify settings, or that back-to-back strobes come out in order. Those outcomes are shown only by the bench's directed and random scenarios against its own model.

// File: rtl/adc_win_pkg.sv
package adc_win_pkg;

    localparam int DEF_RAW_W  = 12;
    localparam int DEF_WORD_W = 16;

    // Captured conversion, one stage ahead of the published word
    typedef struct packed {
        logic                 valid;
        logic                 left;
        logic [DEF_RAW_W-1:0] raw;
    } conv_stage_t;

    // Strict-inside test on unsigned words
    function automatic logic strictly_inside(input logic [DEF_WORD_W-1:0] word,
                                             input logic [DEF_WORD_W-1:0] lo,
                                             input logic [DEF_WORD_W-1:0] hi);
        return (word > lo) && (word < hi);
    endfunction

endpackage

// File: rtl/adc_win_fmt.sv
module adc_win_fmt
    import adc_win_pkg::*;
#(
    parameter int RAW_W     = DEF_RAW_W,
    parameter int WORD_W    = DEF_WORD_W,
    parameter bit SIGN_FILL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  raw_code,
    input  logic              left_just,
    output logic              stage_valid,
    output logic [WORD_W-1:0] fmt_word
);
    localparam int PAD_W = WORD_W - RAW_W;

    conv_stage_t stage_q;
    logic [PAD_W-1:0] fill_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.valid <= conv_done;
            if (conv_done) begin
                stage_q.left <= left_just;
                stage_q.raw  <= raw_code;
            end
        end
    end

    generate
        if (SIGN_FILL) begin : g_sign_fill
            assign fill_bits = {PAD_W{stage_q.raw[RAW_W-1]}};
        end else begin : g_zero_fill
            assign fill_bits = '0;
        end
    endgenerate

    always_comb begin
        if (stage_q.left)
            fmt_word = {stage_q.raw, {PAD_W{1'b0}}};
        else
            fmt_word = {fill_bits, stage_q.raw};
    end

    assign stage_valid = stage_q.valid;

endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp
    import adc_win_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              stage_valid,
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] gt_limit,
    input  logic [WORD_W-1:0] lt_limit,
    output logic              hit
);
    assign hit = stage_valid && strictly_inside(word, gt_limit, lt_limit);
endmodule

// File: rtl/adc_win_flag.sv
module adc_win_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;      // a hit outranks a clear in the same cycle
        else if (clr_i)
            flag_o <= 1'b0;
    end
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
    import adc_win_pkg::*;
#(
    parameter int RAW_W     = DEF_RAW_W,
    parameter int WORD_W    = DEF_WORD_W,
    parameter bit SIGN_FILL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  raw_code,
    input  logic              left_just,
    input  logic [WORD_W-1:0] gt_limit,
    input  logic [WORD_W-1:0] lt_limit,
    input  logic              flag_clr,
    output logic [WORD_W-1:0] data_word,
    output logic              win_flag
);
    logic              stage_valid;
    logic [WORD_W-1:0] fmt_word;
    logic              cmp_hit;

    adc_win_fmt #(.RAW_W(RAW_W), .WORD_W(WORD_W), .SIGN_FILL(SIGN_FILL)) u_fmt (
        .clk         (clk),
        .rst         (rst),
        .conv_done   (conv_done),
        .raw_code    (raw_code),
        .left_just   (left_just),
        .stage_valid (stage_valid),
        .fmt_word    (fmt_word)
    );

    adc_win_cmp #(.WORD_W(WORD_W)) u_cmp (
        .stage_valid (stage_valid),
        .word        (fmt_word),
        .gt_limit    (gt_limit),
        .lt_limit    (lt_limit),
        .hit         (cmp_hit)
    );

    adc_win_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (cmp_hit),
        .clr_i  (flag_clr),
        .flag_o (win_flag)
    );

    // Result word is published in the same cycle the comparison is registered
    always_ff @(posedge clk) begin
        if (rst)
            data_word <= '0;
        else if (stage_valid)
            data_word <= fmt_word;
    end

endmodule

// File: rtl/adc_window_monitor_chk.sv
module adc_window_monitor_chk #(
    parameter int RAW_W     = 12,
    parameter int WORD_W    = 16,
    parameter bit SIGN_FILL = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_done,
    input logic              left_just,
    input logic              flag_clr,
    input logic              stage_valid,
    input logic              cmp_hit,
    input logic [WORD_W-1:0] data_word,
    input logic              win_flag
);
    localparam int PAD_W = WORD_W - RAW_W;

    // R8: every strobe is captured into the stage
    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> stage_valid);

    // R4: a compare hit raises the flag on the next edge
    p_hit_sets_r4: assert property (@(posedge clk) disable iff (rst)
        cmp_hit |=> win_flag);

    // R6: no hit and no clear leaves the flag alone
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cmp_hit && !flag_clr) |=> $stable(win_flag));

    // R7: a clear without a hit drops the flag
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !cmp_hit) |=> !win_flag);

    // R9: word holds when nothing is pending
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !stage_valid |=> $stable(data_word));

    // R2: left-justified result has zero low bits
    p_left_pad_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(conv_done, 2) && $past(left_just, 2))
        |-> (data_word[PAD_W-1:0] == '0));

    // R3: right-justified result carries the configured fill
    p_right_fill_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(conv_done, 2) && !$past(left_just, 2))
        |-> (data_word[WORD_W-1:RAW_W] ==
             (SIGN_FILL ? {PAD_W{data_word[RAW_W-1]}} : {PAD_W{1'b0}})));

endmodule

bind adc_window_monitor adc_window_monitor_chk #(
    .RAW_W(RAW_W), .WORD_W(WORD_W), .SIGN_FILL(SIGN_FILL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_done   (conv_done),
    .left_just   (left_just),
    .flag_clr    (flag_clr),
    .stage_valid (stage_valid),
    .cmp_hit     (cmp_hit),
    .data_word   (data_word),
    .win_flag    (win_flag)
);

// File: tb/adc_window_monitor_tb.sv
module adc_window_monitor_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [11:0] raw_code = '0;
    logic        left_just = 1'b0;
    logic [15:0] gt_limit = '0;
    logic [15:0] lt_limit = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] data_word;
    logic        win_flag;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [15:0] exp_word = '0;
    logic        exp_flag = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    adc_window_monitor u_dut (
        .clk(clk), .rst(rst), .conv_done(conv_done), .raw_code(raw_code),
        .left_just(left_just), .gt_limit(gt_limit), .lt_limit(lt_limit),
        .flag_clr(flag_clr), .data_word(data_word), .win_flag(win_flag)
    );

    function automatic logic [15:0] model_word(input logic [11:0] r, input logic lj);
        return lj ? {r, 4'h0} : {4'h0, r};
    endfunction

    function automatic logic model_in(input logic [15:0] w, input logic [15:0] lo,
                                      input logic [15:0] hi);
        return (w > lo) && (w < hi);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // One conversion; limits held for both edges; optional clear at the compare edge
    task automatic convert(input string req, input logic [11:0] r, input logic lj,
                           input logic [15:0] lo, input logic [15:0] hi, input logic clr_b);
        logic hit;
        conv_done = 1'b1; raw_code = r; left_just = lj; gt_limit = lo; lt_limit = hi;
        @(negedge clk);
        conv_done = 1'b0; flag_clr = clr_b;
        check({req, " R8 word before second edge"}, data_word, exp_word);
        raw_code = ~r; left_just = ~lj;   // capture already done
        @(negedge clk);
        flag_clr = 1'b0;
        exp_word = model_word(r, lj);
        hit = model_in(exp_word, lo, hi);
        exp_flag = hit ? 1'b1 : (clr_b ? 1'b0 : exp_flag);
        check({req, " word"}, data_word, exp_word);
        check({req, " flag"}, {15'b0, win_flag}, {15'b0, exp_flag});
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        exp_flag = 1'b0;
        check("R7 clear", {15'b0, win_flag}, 16'h0);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        conv_done = 1'b1;   // strobe during reset must be ignored
        raw_code = 12'hFFF;
        repeat (3) @(negedge clk);
        check("R1 word in reset", data_word, 16'h0);
        check("R1 flag in reset", {15'b0, win_flag}, 16'h0);
        conv_done = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 word after reset", data_word, 16'h0);
        check("R1 flag after reset", {15'b0, win_flag}, 16'h0);

        // Window 0x1000..0x2000, left-justified
        convert("R6 below", 12'h0FF, 1'b1, 16'h1000, 16'h2000, 1'b0);
        convert("R6 above", 12'h201, 1'b1, 16'h1000, 16'h2000, 1'b0);
        convert("R2 R4 low inside", 12'h101, 1'b1, 16'h1000, 16'h2000, 1'b0);
        convert("R6 stays set", 12'h201, 1'b1, 16'h1000, 16'h2000, 1'b0);
        clear_flag();
        convert("R4 high inside", 12'h1FF, 1'b1, 16'h1000, 16'h2000, 1'b0);
        clear_flag();
        convert("R5 equal lower", 12'h100, 1'b1, 16'h1000, 16'h2000, 1'b0);
        convert("R5 equal upper", 12'h200, 1'b1, 16'h1000, 16'h2000, 1'b0);

        // Right-justified: same code judged on the formatted word
        convert("R3 right inside", 12'hABC, 1'b0, 16'h0A00, 16'h0B00, 1'b0);
        clear_flag();
        convert("R2 left outside", 12'hABC, 1'b1, 16'h0A00, 16'h0B00, 1'b0);
        convert("R3 fill top code", 12'hFFF, 1'b0, 16'h0000, 16'h0000, 1'b0);

        // Hit and clear at the same edge
        convert("R7 hit beats clear", 12'h150, 1'b1, 16'h1000, 16'h2000, 1'b1);
        convert("R7 clear with miss", 12'h050, 1'b1, 16'h1000, 16'h2000, 1'b1);

        // R9: no strobe, inputs wander
        exp_flag = win_flag;
        for (int i = 0; i < 6; i++) begin
            raw_code = 12'($urandom); left_just = 1'($urandom);
            gt_limit = 16'h0000; lt_limit = 16'hFFFF;
            @(negedge clk);
        end
        check("R9 word held", data_word, exp_word);
        check("R9 flag held", {15'b0, win_flag}, {15'b0, exp_flag});

        // R10: back-to-back strobes
        gt_limit = 16'h0800; lt_limit = 16'h0900;
        conv_done = 1'b1; raw_code = 12'h123; left_just = 1'b0;
        @(negedge clk);
        raw_code = 12'h850; left_just = 1'b0;
        @(negedge clk);
        conv_done = 1'b0;
        check("R10 first word", data_word, 16'h0123);
        check("R10 first no hit", {15'b0, win_flag}, 16'h0);
        @(negedge clk);
        check("R10 second word", data_word, 16'h0850);
        check("R10 second hit", {15'b0, win_flag}, 16'h1);
        exp_word = 16'h0850; exp_flag = 1'b1;
        clear_flag();

        // Random conversions around the window edges
        for (int i = 0; i < 400; i++) begin
            logic [11:0] r;
            logic        lj;
            logic [15:0] w, lo, hi;
            r  = 12'($urandom);
            lj = 1'($urandom);
            w  = model_word(r, lj);
            case ($urandom % 4)
                0: begin lo = w; hi = w + 16'($urandom % 64); end
                1: begin lo = w - 16'($urandom % 64); hi = w; end
                2: begin lo = w - 16'd1 - 16'($urandom % 32); hi = w + 16'd1 + 16'($urandom % 32); end
                default: begin lo = 16'($urandom); hi = 16'($urandom); end
            endcase
            convert("R4 R5 R6 random", r, lj, lo, hi, 1'($urandom % 5 == 0));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule